// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst access. When a new access begins, one of two active-low strobes captures the full external address. The block then presents that address, with the two low bits stepping through a four-beat pattern each time the active-low advance input is sampled low. While advance is high, the address holds, which suspends the burst. After the fourth beat the pattern wraps back to the starting address.

Two orderings are available. Linear order adds the beat count to the start bits, modulo four. Interleaved order XORs the start bits with the beat count. The order-select input is captured together with the address at each load, so a burst keeps the order it began with. The upper address bits come straight from the load register. The block also reports the current beat number and flags the final beat.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released with no load, `addr_out` is all zeros, `beat_idx` is 0 and `last_beat` is 0.
- R2: A rising edge with `ctrl_strobe_n` low loads the block whatever the value of `chip_en_n`. From the next cycle `addr_out` equals the captured `ext_addr` and `beat_idx` is 0.
- R3: `proc_strobe_n` low loads only when `chip_en_n` is also low. With `chip_en_n` high it has no effect, and the address and beat hold or advance as they would without it.
- R4: With linear order captured (`order_sel` = 0 at the load), `addr_out[1:0]` equals (start bits + `beat_idx`) modulo 4.
- R5: With interleaved order captured (`order_sel` = 1 at the load), `addr_out[1:0]` equals the start bits XOR `beat_idx`.
- R6: On an edge with no load, `adv_n` low increments `beat_idx` by one, and `adv_n` high holds both `beat_idx` and `addr_out` unchanged.
- R7: An advance from beat 3 returns `beat_idx` to 0 and `addr_out` to the loaded start address.
- R8: When a load and `adv_n` low fall on the same edge, the load wins: `beat_idx` becomes 0 and no step is taken.
- R9: `last_beat` is 1 exactly when `beat_idx` equals 3.
- R10: A change of `order_sel` between loads does not alter the ordering of the burst in progress.
- R11: `addr_out[ADDR_W-1:2]` changes only on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_addr | input | ADDR_W | External start address |
| proc_strobe_n | input | 1 | Active-low load strobe, gated by chip enable |
| ctrl_strobe_n | input | 1 | Active-low load strobe, ungated |
| chip_en_n | input | 1 | Active-low chip enable gating `proc_strobe_n` |
| adv_n | input | 1 | Active-low burst advance |
| order_sel | input | 1 | Order captured at load: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current burst address |
| beat_idx | output | 2 | Current beat number, 0 to 3 |
| last_beat | output | 1 | High on the fourth beat |

## Verification
A load and an advance can fall on the same clock edge. The bench provokes this by asserting a strobe together with `adv_n` low, both mid-burst and at the last beat, and expects the new start address with beat 0. A gated processor strobe with chip enable high can also coincide with an advance. Here the bench expects a plain step with no reload. A behavioural model predicts every cycle, and the bench compares all three outputs against it.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    // Burst length is fixed at four beats
    localparam int BEATS  = 4;
    localparam int BEAT_W = $clog2(BEATS);

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/bseq_strobe_dec.sv
module bseq_strobe_dec (
    input  logic proc_strobe_n,
    input  logic ctrl_strobe_n,
    input  logic chip_en_n,
    input  logic adv_n,
    output logic load,
    output logic step
);
    logic proc_load;

    always_comb begin
        // The processor strobe counts only while the chip is enabled
        proc_load = !proc_strobe_n && !chip_en_n;
        load      = !ctrl_strobe_n || proc_load;
        // A load overrides an advance on the same edge
        step      = !adv_n && !load;
    end
endmodule

// File: rtl/bseq_low_map.sv
module bseq_low_map
    import bseq_pkg::*;
(
    input  logic [BEAT_W-1:0] start_bits,
    input  logic [BEAT_W-1:0] beat,
    input  order_e            mode,
    output logic [BEAT_W-1:0] low_bits
);
    logic [BEAT_W-1:0] lin_bits;
    logic [BEAT_W-1:0] ilv_bits;

    always_comb begin
        lin_bits = start_bits + beat;
        ilv_bits = start_bits ^ beat;
        low_bits = (mode == ORD_INTERLEAVE) ? ilv_bits : lin_bits;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              chip_en_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat_idx,
    output logic              last_beat
);
    localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);
    localparam logic [BEAT_W-1:0] ONE_IDX  = BEAT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        order_e            mode;
        logic [BEAT_W-1:0] beat;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       load, step;
    logic [BEAT_W-1:0] low_bits;

    bseq_strobe_dec u_dec (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .chip_en_n     (chip_en_n),
        .adv_n         (adv_n),
        .load          (load),
        .step          (step)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.base = ext_addr;
            st_d.mode = order_e'(order_sel);
            st_d.beat = '0;
        end else if (step) begin
            st_d.beat = st_q.beat + ONE_IDX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{base: '0, mode: ORD_LINEAR, beat: '0};
        end else begin
            st_q <= st_d;
        end
    end

    bseq_low_map u_map (
        .start_bits (st_q.base[BEAT_W-1:0]),
        .beat       (st_q.beat),
        .mode       (st_q.mode),
        .low_bits   (low_bits)
    );

    assign addr_out  = {st_q.base[ADDR_W-1:BEAT_W], low_bits};
    assign beat_idx  = st_q.beat;
    assign last_beat = (st_q.beat == LAST_IDX);
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              proc_strobe_n,
    input logic              ctrl_strobe_n,
    input logic              chip_en_n,
    input logic              adv_n,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        beat_idx,
    input logic              last_beat
);
    logic any_load;
    assign any_load = !ctrl_strobe_n || (!proc_strobe_n && !chip_en_n);

    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_strobe_n |=> (addr_out == $past(ext_addr)) && (beat_idx == 2'd0));

    assert_gated_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && !chip_en_n) |=> (beat_idx == 2'd0));

    assert_advance_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_load && !adv_n) |=> (beat_idx == $past(beat_idx) + 2'd1));

    assert_suspend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_load && adv_n) |=> ($stable(addr_out) && $stable(beat_idx)));

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (any_load && !adv_n) |=> (beat_idx == 2'd0));

    assert_last_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !any_load && !adv_n) |=> (!last_beat && beat_idx == 2'd0));

    assert_upper_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !any_load |=> $stable(addr_out[ADDR_W-1:2]));
endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_addr      (ext_addr),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .chip_en_n     (chip_en_n),
    .adv_n         (adv_n),
    .addr_out      (addr_out),
    .beat_idx      (beat_idx),
    .last_beat     (last_beat)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          proc_strobe_n = 1'b1;
    logic          ctrl_strobe_n = 1'b1;
    logic          chip_en_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_idx;
    logic          last_beat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state
    logic [AW-1:0] m_base = '0;
    int            m_cnt = 0;
    bit            m_ilv = 0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_addr      (ext_addr),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .chip_en_n     (chip_en_n),
        .adv_n         (adv_n),
        .order_sel     (order_sel),
        .addr_out      (addr_out),
        .beat_idx      (beat_idx),
        .last_beat     (last_beat)
    );

    function automatic logic [AW-1:0] model_addr();
        int s;
        int lo;
        s  = int'(m_base[1:0]);
        lo = m_ilv ? (s ^ m_cnt) : ((s + m_cnt) % 4);
        return {m_base[AW-1:2], 2'(lo)};
    endfunction

    task automatic compare(input string tag);
        logic [AW-1:0] ea;
        ea = model_addr();
        checks++;
        if (addr_out !== ea || beat_idx !== 2'(m_cnt) || last_beat !== (m_cnt == 3)) begin
            errors++;
            $display("FAIL %s addr=%h beat=%0d last=%0b expected addr=%h beat=%0d last=%0b",
                     tag, addr_out, beat_idx, last_beat, ea, m_cnt, (m_cnt == 3));
        end
    endtask

    // One clock: drive at negedge, model updates at posedge, compare at next negedge
    task automatic cyc(input logic [AW-1:0] a, input logic pn, input logic cn,
                       input logic ce, input logic av, input logic md, input string tag);
        ext_addr = a; proc_strobe_n = pn; ctrl_strobe_n = cn;
        chip_en_n = ce; adv_n = av; order_sel = md;
        @(posedge clk);
        if (!cn || (!pn && !ce)) begin
            m_base = a; m_cnt = 0; m_ilv = md;
        end else if (!av) begin
            m_cnt = (m_cnt + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        cyc('0, 1, 1, 1, 1, 0, "R1 idle after reset");

        // R2 + R4 + R7: controller strobe load, linear order, advance past wrap
        cyc(19'h12345, 1, 0, 1, 1, 0, "R2 ctrl load");
        for (int i = 0; i < 5; i++) cyc('0, 1, 1, 1, 0, 0, "R4 R7 R9 linear advance");

        // R3 + R5: gated processor strobe load, interleaved
        cyc(19'h0ABC1, 0, 1, 0, 1, 1, "R3 proc load enabled");
        for (int i = 0; i < 4; i++) cyc('0, 1, 1, 1, 0, 1, "R5 interleaved advance");

        // Every start value under both orders
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++) begin
                cyc(19'h55550 | AW'(s), 1, 0, 0, 1, m[0], "R2 load sweep");
                for (int i = 0; i < 4; i++)
                    cyc('0, 1, 1, 1, 0, 1'b0, m[0] ? "R5 sweep" : "R4 sweep");
            end

        // R6: suspend mid-burst
        cyc(19'h7FFF2, 1, 0, 1, 1, 0, "R2 load for suspend");
        cyc('0, 1, 1, 1, 0, 0, "R6 step");
        cyc('0, 1, 1, 1, 1, 0, "R6 hold");
        cyc('0, 1, 1, 1, 1, 0, "R6 hold again");
        cyc('0, 1, 1, 1, 0, 0, "R6 resume");

        // R3: gated strobe ignored while chip enable high, with and without advance
        cyc(19'h00003, 0, 1, 1, 1, 1, "R3 ignored hold");
        cyc(19'h00003, 0, 1, 1, 0, 1, "R3 ignored step");

        // R10: order select toggled mid-burst has no effect
        cyc('0, 1, 1, 1, 0, 1, "R10 mode change ignored");
        cyc('0, 1, 1, 1, 0, 0, "R10 mode restored");

        // R8: load together with advance, mid-burst and at last beat
        cyc(19'h2AAA1, 1, 0, 1, 0, 1, "R8 ctrl load with advance");
        cyc('0, 1, 1, 1, 0, 0, "R8 step");
        cyc('0, 1, 1, 1, 0, 0, "R8 step");
        cyc('0, 1, 1, 1, 0, 0, "R9 last beat");
        cyc(19'h13572, 0, 1, 0, 0, 0, "R8 proc load at last beat with advance");
        cyc('0, 1, 1, 1, 0, 0, "R11 upper bits held");

        done = 1;
        summary();
    end
endmodule